// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by software into asynchronous serial frames on one output line. A one-byte holding register sits in front of a separate frame shifter. Software can therefore queue the next byte while the current frame is still leaving the shifter. Bit timing comes from outside the block: a single-cycle `bit_tick` pulse, typically from a programmable timer, advances the line by one bit. The block does no baud division of its own.

The frame format is latched from the configuration inputs while the enable input is low, and it is frozen while the block runs. The format covers a short or full data width, an optional even or odd parity bit, and one or two stop bits. Two status flags are exposed. `buf_empty` shows that the holding register can accept a byte. `shift_busy` shows that a frame is on the line. A registered interrupt request follows `buf_empty` when the interrupt is enabled. Pulling the enable low aborts the current frame and drops any queued byte.

Top module: `uart_tx_dbuf`

## Requirements
- R1: The state after reset, and the state at every clock edge that samples `en` low, is `txd`=1, `buf_empty`=1, `shift_busy`=0. After reset `irq`=0. A write while `en`=0 is ignored.
- R2: A frame is a start bit of 0, then the data bits least-significant first, then the parity bit if enabled, then stop bits of 1. The data is `DATA_W` bits wide, or `DATA_W`-1 bits when `cfg_short`=1. There is one stop bit, or two when `cfg_two_stop`=1. Each bit changes on the clock edge that samples `bit_tick` high.
- R3: When `cfg_par_en`=1 and `cfg_par_odd`=0, the parity bit makes the count of ones over the data bits and parity even. When `cfg_par_odd`=1, that count is odd.
- R4: `buf_empty` falls on the edge that samples an enabled write. It rises on the tick edge that moves the held byte into the shifter.
- R5: `shift_busy` rises on the tick edge that loads a byte, together with the start bit. It falls on the tick after the last stop bit when no byte is waiting. At that point `txd` returns to 1.
- R6: If a byte is held when the last stop bit ends, the next tick starts its start bit at once. `shift_busy` stays 1.
- R7: A write while `buf_empty`=0 replaces the held byte. The replaced byte is never sent.
- R8: `irq` is a register. In every cycle after reset it equals the previous cycle's `irq_en` ANDed with the current `buf_empty`.
- R9: Driving `en` low in the middle of a frame stops the frame at the next edge and discards any held byte. After re-enabling, a tick sends nothing.
- R10: The format inputs are captured only while `en`=0. Changing them while `en`=1 does not alter the frames sent.
- R11: When a write and a load fall in the same cycle, the shifter takes the older held byte and the new byte stays queued, so `buf_empty` remains 0. A write on a tick while the buffer is empty and the shifter is idle is not loaded until the next tick.
- R12: A held byte waits, with `shift_busy`=0, until `bit_tick` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low clears the block and opens the format latch |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to queue |
| cfg_short | input | 1 | Send DATA_W-1 data bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Odd parity when set, even when clear |
| cfg_two_stop | input | 1 | Two stop bits when set |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |
| shift_busy | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land in the same clock cycle: a software write to the holding register, and the tick that moves the held byte into the shifter. The bench provokes this in two ways. In the first, it asserts `wr_en` together with the `bit_tick` that ends a frame while another byte is already held. The expected result is that the older byte's start bit appears, `buf_empty` stays low and the new byte follows back-to-back. In the second, it asserts the same pair while the block is idle with an empty buffer. The expected result is that nothing starts until a later tick. Random traffic across all formats is decoded bit by bit against frames the bench builds from the requirements.

// File: rtl/txb_pkg.sv
package txb_pkg;

  // Latched frame format
  typedef struct packed {
    logic short_data;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } txb_cfg_t;

endpackage

// File: rtl/txb_holdbuf.sv
module txb_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              empty_q,
  output logic              empty_d,
  output logic [DATA_W-1:0] data_q
);

  // A write wins over a take in the same cycle: the shifter has already
  // captured the old contents, the new byte stays queued.
  always_comb begin
    empty_d = empty_q;
    if (clr)       empty_d = 1'b1;
    else if (wr)   empty_d = 1'b0;
    else if (take) empty_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) empty_q <= 1'b1;
    else     empty_q <= empty_d;
  end

  // Data storage needs no reset; validity is carried by empty_q
  always_ff @(posedge clk) begin
    if (wr && !clr) data_q <= wdata;
  end

endmodule

// File: rtl/txb_shifter.sv
module txb_shifter
  import txb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  txb_cfg_t          cfg,
  input  logic              have,
  input  logic [DATA_W-1:0] hdata,
  output logic              take,
  output logic              txd,
  output logic              busy
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   nd;
  logic [CNT_W-1:0]   last;
  logic [DATA_W-1:0]  dmask;
  logic               par;
  logic               at_end;

  // Build the whole frame, start bit at index 0
  always_comb begin
    nd    = cfg.short_data ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    dmask = hdata;
    if (cfg.short_data) dmask[DATA_W-1] = 1'b0;
    par   = (^dmask) ^ cfg.par_odd;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < nd) frame[i+1] = hdata[i];
    end
    if (cfg.par_en) begin
      for (int j = 1; j < FRAME_W; j++) begin
        if (CNT_W'(j) == nd + CNT_W'(1)) frame[j] = par;
      end
    end
    last = nd + CNT_W'(cfg.par_en) + CNT_W'(1) + CNT_W'(cfg.two_stop);
  end

  assign at_end = (cnt_q == '0);
  assign take   = tick && have && !clr && (!busy || at_end);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      sr_q  <= '1;
      cnt_q <= '0;
    end else if (tick) begin
      if (take) begin
        sr_q  <= frame;
        txd   <= frame[0];
        busy  <= 1'b1;
        cnt_q <= last;
      end else if (busy) begin
        if (!at_end) begin
          sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
          txd   <= sr_q[1];
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import txb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              irq_en,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_busy,
  output logic              irq
);

  txb_cfg_t          cfg_q;
  logic              clr;
  logic              wr;
  logic              take;
  logic              empty_d;
  logic [DATA_W-1:0] hold_data;

  assign clr = !en;
  assign wr  = wr_en && en;

  // Format latch: transparent only while disabled
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (!en) cfg_q <= '{short_data: cfg_short, par_en: cfg_par_en,
                             par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  end

  txb_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .wr      (wr),
    .wdata   (wr_data),
    .take    (take),
    .empty_q (buf_empty),
    .empty_d (empty_d),
    .data_q  (hold_data)
  );

  txb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .tick  (bit_tick),
    .cfg   (cfg_q),
    .have  (!buf_empty),
    .hdata (hold_data),
    .take  (take),
    .txd   (txd),
    .busy  (shift_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && empty_d;
  end

endmodule

// File: rtl/txb_chk.sv
module txb_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              bit_tick,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_en,
  input logic              txd,
  input logic              buf_empty,
  input logic              shift_busy,
  input logic              irq
);

  logic primed = 1'b0;
  always_ff @(posedge clk) if (rst) primed <= 1'b1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (txd && buf_empty && !shift_busy && !irq));

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    !en |=> (txd && buf_empty && !shift_busy));

  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    !shift_busy |-> txd);

  // R5
  start_bit_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    $rose(shift_busy) |-> (!txd && $past(bit_tick)));

  // R4
  write_clear_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    (en && wr_en) |=> !buf_empty);

  // R12
  load_on_tick_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    ($rose(buf_empty) && $past(en) && !$past(rst)) |-> $past(bit_tick));

  // R2
  txd_on_tick_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    ((txd != $past(txd)) && $past(en) && !$past(rst)) |-> $past(bit_tick));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    !$past(rst) |-> (irq == ($past(irq_en) && buf_empty)));

endmodule

bind uart_tx_dbuf txb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .bit_tick   (bit_tick),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .irq_en     (irq_en),
  .txd        (txd),
  .buf_empty  (buf_empty),
  .shift_busy (shift_busy),
  .irq        (irq)
);

// File: tb/sim_uart_tx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_tx_dbuf;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       c_short = 1'b0, c_pe = 1'b0, c_po = 1'b0, c_s2 = 1'b0;
  logic       irq_en = 1'b0;
  logic       txd, buf_empty, shift_busy, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit m_short, m_pe, m_po, m_s2;

  always #2.5 clk = ~clk;

  uart_tx_dbuf #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .en(en), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_short(c_short), .cfg_par_en(c_pe),
    .cfg_par_odd(c_po), .cfg_two_stop(c_s2), .irq_en(irq_en),
    .txd(txd), .buf_empty(buf_empty), .shift_busy(shift_busy), .irq(irq)
  );

  function automatic int n_data();
    return m_short ? 7 : 8;
  endfunction

  function automatic int n_bits();
    return 1 + n_data() + int'(m_pe) + 1 + int'(m_s2);
  endfunction

  function automatic logic exp_bit(logic [7:0] d, int k);
    logic p;
    if (k == 0) return 1'b0;
    if (k <= n_data()) return d[k-1];
    if (m_pe && k == n_data() + 1) begin
      p = 1'b0;
      for (int i = 0; i < n_data(); i++) p ^= d[i];
      return p ^ m_po;
    end
    return 1'b1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic wr_byte(logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic wr_tick(logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; bit_tick = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; bit_tick = 1'b0; end
  endtask

  task automatic setup(bit s, bit pe, bit po, bit s2);
    @(negedge clk) begin en = 1'b0; c_short = s; c_pe = pe; c_po = po; c_s2 = s2; end
    @(negedge clk) en = 1'b1;
    m_short = s; m_pe = pe; m_po = po; m_s2 = s2;
  endtask

  // Start bit already on the line; walk up to the last stop bit
  task automatic body(logic [7:0] d);
    check("R2", "start bit", int'(txd), 0);
    for (int k = 1; k < n_bits(); k++) begin
      tick1();
      if (m_pe && k == n_data() + 1) check("R3", "parity bit", int'(txd), int'(exp_bit(d, k)));
      else                            check("R2", "frame bit", int'(txd), int'(exp_bit(d, k)));
      check("R5", "busy in frame", int'(shift_busy), 1);
    end
  endtask

  task automatic send_one(logic [7:0] d);
    wr_byte(d);
    check("R4", "empty after write", int'(buf_empty), 0);
    check("R8", "irq after write", int'(irq), 0);
    tick1();
    check("R4", "empty after load", int'(buf_empty), 1);
    check("R5", "busy after load", int'(shift_busy), 1);
    check("R8", "irq after load", int'(irq), int'(irq_en));
    body(d);
    tick1();
    check("R5", "busy at end", int'(shift_busy), 0);
    check("R5", "line idle", int'(txd), 1);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", "txd in reset", int'(txd), 1);
    check("R1", "empty in reset", int'(buf_empty), 1);
    check("R1", "busy in reset", int'(shift_busy), 0);
    check("R1", "irq in reset", int'(irq), 0);
    rst = 1'b0;

    // R1: write while disabled is ignored
    wr_byte(8'h55);
    check("R1", "empty after disabled write", int'(buf_empty), 1);
    setup(0, 0, 0, 0);
    tick1();
    check("R1", "nothing sent", int'(shift_busy), 0);

    // R12: held byte waits for a tick
    wr_byte(8'hA5);
    repeat (5) @(negedge clk);
    check("R12", "busy before tick", int'(shift_busy), 0);
    check("R12", "still held", int'(buf_empty), 0);
    tick1();
    check("R12", "loaded on tick", int'(shift_busy), 1);
    body(8'hA5);
    tick1();

    // All format combinations
    for (int c = 0; c < 16; c++) begin
      setup(c[0], c[1], c[2], c[3]);
      irq_en = c[0] ^ c[3];
      send_one(8'hC3 ^ 8'(c * 37));
    end

    // R8: irq follows enable and flag
    irq_en = 1'b0;
    @(negedge clk);
    @(negedge clk) check("R8", "irq masked", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk) check("R8", "irq raised", int'(irq), 1);

    // R6: back-to-back frames
    setup(0, 0, 0, 0);
    wr_byte(8'h3C);
    tick1();
    wr_byte(8'hE1);
    check("R6", "second queued", int'(buf_empty), 0);
    body(8'h3C);
    tick1();
    check("R6", "next start bit", int'(txd), 0);
    check("R6", "busy held", int'(shift_busy), 1);
    check("R6", "buffer moved", int'(buf_empty), 1);
    body(8'hE1);
    tick1();

    // R7: overwrite of a held byte
    wr_byte(8'h11);
    tick1();
    wr_byte(8'h22);
    wr_byte(8'h33);
    body(8'h11);
    tick1();
    body(8'h33);
    tick1();
    check("R7", "replaced byte dropped", int'(shift_busy), 0);
    check("R7", "buffer empty", int'(buf_empty), 1);

    // R11: write on the tick that reloads the shifter
    wr_byte(8'h44);
    tick1();
    wr_byte(8'h66);
    body(8'h44);
    wr_tick(8'h77);
    check("R11", "older byte starts", int'(txd), 0);
    check("R11", "busy", int'(shift_busy), 1);
    check("R11", "new byte queued", int'(buf_empty), 0);
    body(8'h66);
    tick1();
    body(8'h77);
    tick1();
    // R11: write on a tick while idle and empty
    wr_tick(8'h5A);
    check("R11", "not loaded yet", int'(shift_busy), 0);
    check("R11", "held", int'(buf_empty), 0);
    tick1();
    body(8'h5A);
    tick1();

    // R10: format frozen while enabled
    setup(0, 0, 0, 0);
    c_short = 1'b1; c_pe = 1'b1; c_po = 1'b1; c_s2 = 1'b1;
    send_one(8'h96);
    check("R10", "frame length kept", int'(txd), 1);
    c_short = 1'b0; c_pe = 1'b0; c_po = 1'b0; c_s2 = 1'b0;

    // R9: disable in mid-frame with a byte queued
    wr_byte(8'hF0);
    tick1();
    tick1();
    wr_byte(8'h0F);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check("R9", "line idle", int'(txd), 1);
    check("R9", "busy cleared", int'(shift_busy), 0);
    check("R9", "buffer cleared", int'(buf_empty), 1);
    en = 1'b1;
    tick1();
    check("R9", "queued byte dropped", int'(shift_busy), 0);

    // Random traffic
    for (int n = 0; n < 40; n++) begin
      logic [3:0] r;
      logic [7:0] d;
      r = 4'($urandom);
      d = 8'($urandom);
      setup(r[0], r[1], r[2], r[3]);
      irq_en = 1'($urandom);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      send_one(d);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule